// File: doc/BRIEF.md
# Dual-Mode Chained Multiply-Accumulate Unit Pair

The block holds two complex functional units side by side. Each unit has a multiply-accumulate path that runs in parallel with an ALU followed by a shifter. A per-unit select bit picks which of the two results the unit delivers. The ALU has no pass-through operation, so all eight of its codes do real work. The multiplier forms partial products, reduces them in carry-save form, and finishes with one final addition. It handles signed or unsigned operands.

A configuration word sets the two units. In independent mode, each unit computes its own 32-bit result from its own operands. Chained mode has two forms. In the first, the result of unit 0 becomes the first operand of unit 1 within the same cycle. In the second, unit 0 forms the low word of a 64-bit operation and passes its adder carry to unit 1, which forms the high word. That wide form also gives a full 64-bit multiply-accumulate.

The four operands and the configuration word are sampled on a clock edge, and both results appear registered after that edge.

Top module: `cmac_pair`

## Requirements
- R1: While `rst_n` is low, both results read 0. A set of inputs applied before a rising clock edge appears on `res_lo`/`res_hi` after that edge and not before.
- R2: ALU code, `cfg[4:2]` for unit 0 and `cfg[16:14]` for unit 1, with x the first and y the second operand: 0 gives x+y, 1 gives x-y, 2 gives x&y, 3 gives x|y, 4 gives x^y, 5 gives ~(x|y), 6 gives x&~y, 7 gives y-x. Outside wide mode the carry into the adder is 0 for code 0 and 1 for the subtracting codes.
- R3: The ALU result passes through a shifter. The shift kind is `cfg[6:5]` for unit 0 and `cfg[18:17]` for unit 1. The shift amount is `cfg[11:7]` for unit 0 and `cfg[23:19]` for unit 1. Kind 0 shifts left logical, 1 shifts right logical, 2 shifts right arithmetic and 3 rotates right.
- R4: Select bit `cfg[12]` for unit 0 and `cfg[24]` for unit 1. A value of 1 delivers x*y+acc, truncated to 32 bits. A value of 0 delivers the shifter output.
- R5: Independent mode, `cfg[0]`=0: unit 0 uses x=opa, y=opb, acc=opc and drives `res_lo`. Unit 1 uses x=opc, y=opd, acc=opa and drives `res_hi`.
- R6: Chained feed mode, `cfg[0]`=1 and `cfg[1]`=0: unit 0 behaves as in R5. Unit 1 takes x from the unit 0 result in the same cycle, with y=opd and acc=opc.
- R7: Wide mode, `cfg[0]`=1 and `cfg[1]`=1, with `cfg[12]`=0: unit 0's ALU code applies to {opc,opa} and {opd,opb} as 64-bit values. The carry-out of the low word enters the high word. `res_lo` is the low word and `res_hi` is the high word. Logic codes act word by word. All shift fields and unit 1's code and select are ignored.
- R8: Wide mode with `cfg[12]`=1: {res_hi,res_lo} = opa*opb + {opd,opc} over 64 bits. `cfg[13]`=1 treats opa and opb as signed, and 0 treats them as unsigned. Outside wide mode `cfg[13]` has no effect on any result.
- R9: With `cfg[0]`=0, the value of `cfg[1]` has no effect on either result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| opc | input | 32 | Operand C |
| opd | input | 32 | Operand D |
| cfg | input | 25 | Configuration word (fields in R2 to R9) |
| res_lo | output | 32 | Unit 0 result, or low word in wide mode |
| res_hi | output | 32 | Unit 1 result, or high word in wide mode |

## Verification
The riskiest coincidence is a low-word carry or borrow that must cross into the high word in the same cycle as the subtract inversion of the high word's operand. Directed vectors force this case: all-ones plus one, zero minus one, and a reversed subtract whose low word borrows. The bench compares the 64-bit result with plain wide arithmetic in a bench function. The second coincidence is a chained feed in which unit 1 consumes a shifted or multiplied unit 0 result in the same cycle. Random configurations cover this case, and each output is compared with a two-stage model of the same cycle.

// File: rtl/cmac_pair.sv
module cmac_pair #(
  parameter int W = 32,
  localparam int SW = $clog2(W),
  localparam int UF = SW + 7,
  localparam int CW = 2 + UF + (UF - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [W-1:0]  opc,
  input  logic [W-1:0]  opd,
  input  logic [CW-1:0] cfg,
  output logic [W-1:0]  res_lo,
  output logic [W-1:0]  res_hi
);
  localparam int U0 = 2;
  localparam int U1 = 2 + UF;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
                         OP_XOR = 3'd4, OP_NOR = 3'd5, OP_ANDN = 3'd6, OP_RSUB = 3'd7;

  logic          chain, wide, sel0, sel1, sgn0;
  logic [2:0]    op0, op1;
  logic [1:0]    sh0, sh1;
  logic [SW-1:0] amt0, amt1;

  assign chain = cfg[0];
  assign wide  = cfg[1];
  assign op0   = cfg[U0 +: 3];
  assign sh0   = cfg[U0+3 +: 2];
  assign amt0  = cfg[U0+5 +: SW];
  assign sel0  = cfg[U0+5+SW];
  assign sgn0  = cfg[U0+6+SW];
  assign op1   = cfg[U1 +: 3];
  assign sh1   = cfg[U1+3 +: 2];
  assign amt1  = cfg[U1+5 +: SW];
  assign sel1  = cfg[U1+5+SW];

  function automatic logic [W:0] alu_f(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic [2:0] op, input logic cin);
    case (op)
      OP_ADD:  return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
      OP_SUB:  return {1'b0, x} + {1'b0, ~y} + {{W{1'b0}}, cin};
      OP_RSUB: return {1'b0, ~x} + {1'b0, y} + {{W{1'b0}}, cin};
      OP_AND:  return {1'b0, x & y};
      OP_OR:   return {1'b0, x | y};
      OP_XOR:  return {1'b0, x ^ y};
      OP_NOR:  return {1'b0, ~(x | y)};
      default: return {1'b0, x & ~y};
    endcase
  endfunction

  function automatic logic [W-1:0] shf(input logic [W-1:0] v, input logic [1:0] kind,
                                       input logic [SW-1:0] n);
    case (kind)
      2'd0:    return v << n;
      2'd1:    return v >> n;
      2'd2:    return $unsigned($signed(v) >>> n);
      default: return W'({v, v} >> n);
    endcase
  endfunction

  function automatic logic [2*W-1:0] mac_f(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic [2*W-1:0] acc, input logic sgn);
    logic [2*W-1:0] xe, ye, s, c, pp, ns;
    xe = sgn ? {{W{x[W-1]}}, x} : {{W{1'b0}}, x};
    ye = sgn ? {{W{y[W-1]}}, y} : {{W{1'b0}}, y};
    s  = acc;
    c  = '0;
    for (int i = 0; i < 2*W; i++) begin
      pp = ye[i] ? (xe << i) : '0;
      ns = s ^ c ^ pp;
      c  = ((s & c) | (s & pp) | (c & pp)) << 1;
      s  = ns;
    end
    return s + c;
  endfunction

  logic           wmode;
  logic [W:0]     a0;
  logic [W-1:0]   a1, r0, r1, x1, acc1, mac1, lo_n, hi_n;
  logic [2*W-1:0] acc0, mac0;

  assign wmode = chain && wide;
  assign acc0  = wmode ? {opd, opc} : {{W{1'b0}}, opc};
  assign mac0  = mac_f(opa, opb, acc0, sgn0);
  assign a0    = alu_f(opa, opb, op0, op0 != OP_ADD);
  assign r0    = sel0 ? mac0[W-1:0] : shf(a0[W-1:0], sh0, amt0);

  assign x1    = (chain && !wide) ? r0 : opc;
  assign acc1  = chain ? opc : opa;
  assign mac1  = W'(mac_f(x1, opd, {{W{1'b0}}, acc1}, 1'b0));
  assign a1    = wmode ? W'(alu_f(opc, opd, op0, a0[W]))
                       : W'(alu_f(x1, opd, op1, op1 != OP_ADD));
  assign r1    = sel1 ? mac1 : shf(a1, sh1, amt1);

  assign lo_n  = wmode ? (sel0 ? mac0[W-1:0] : a0[W-1:0]) : r0;
  assign hi_n  = wmode ? (sel0 ? mac0[2*W-1:W] : a1) : r1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_lo <= '0;
      res_hi <= '0;
    end else begin
      res_lo <= lo_n;
      res_hi <= hi_n;
    end
  end

  a_r7_wide_add: assert property (@(posedge clk) disable iff (!rst_n)
    (wmode && !sel0 && op0 == OP_ADD) |=> ({res_hi, res_lo} == $past({opc, opa} + {opd, opb})));

  a_r7_wide_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (wmode && !sel0 && op0 == OP_SUB) |=> ({res_hi, res_lo} == $past({opc, opa} - {opd, opb})));

  a_r6_chain_feed: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && !wide && op1 == OP_ADD && !sel1 && amt1 == '0) |=> (res_hi == res_lo + $past(opd)));

  a_r4_mac_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain && sel0) |=> (res_lo == $past(opa * opb + opc)));

  a_r5_indep_and: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain && !sel0 && op0 == OP_AND && amt0 == '0) |=> (res_lo == $past(opa & opb)));
endmodule

// File: tb/cmac_pair_bench.sv
module cmac_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0, opb = '0, opc = '0, opd = '0;
  logic [24:0] cfg = '0;
  logic [31:0] res_lo, res_hi;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmac_pair u_cmac_pair (.clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .opc(opc),
                         .opd(opd), .cfg(cfg), .res_lo(res_lo), .res_hi(res_hi));

  function automatic logic [24:0] mk(input logic chain, input logic wide,
      input logic [2:0] op0, input logic [1:0] sh0, input logic [4:0] n0, input logic sel0,
      input logic sgn0, input logic [2:0] op1, input logic [1:0] sh1, input logic [4:0] n1,
      input logic sel1);
    return {sel1, n1, sh1, op1, sgn0, sel0, n0, sh0, op0, wide, chain};
  endfunction

  function automatic logic [31:0] unit_m(input logic [31:0] x, input logic [31:0] y,
      input logic [31:0] acc, input logic [2:0] op, input logic [1:0] sh, input logic [4:0] n,
      input logic sel);
    logic [31:0] v;
    if (sel) return x * y + acc;
    case (op)
      3'd0: v = x + y;
      3'd1: v = x - y;
      3'd2: v = x & y;
      3'd3: v = x | y;
      3'd4: v = x ^ y;
      3'd5: v = ~(x | y);
      3'd6: v = x & ~y;
      default: v = y - x;
    endcase
    case (sh)
      2'd0: return v << n;
      2'd1: return v >> n;
      2'd2: return $unsigned($signed(v) >>> n);
      default: return (v >> n) | (v << (6'd32 - {1'b0, n}));
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] c, input logic [31:0] d, input logic [24:0] f);
    logic [63:0] sa, sb;
    logic [31:0] u0;
    if (f[0] && f[1]) begin
      if (f[12]) begin
        sa = f[13] ? {{32{a[31]}}, a} : {32'b0, a};
        sb = f[13] ? {{32{b[31]}}, b} : {32'b0, b};
        return sa * sb + {d, c};
      end
      case (f[4:2])
        3'd0: return {c, a} + {d, b};
        3'd1: return {c, a} - {d, b};
        3'd2: return {c & d, a & b};
        3'd3: return {c | d, a | b};
        3'd4: return {c ^ d, a ^ b};
        3'd5: return {~(c | d), ~(a | b)};
        3'd6: return {c & ~d, a & ~b};
        default: return {d, b} - {c, a};
      endcase
    end
    u0 = unit_m(a, b, c, f[4:2], f[6:5], f[11:7], f[12]);
    if (f[0]) return {unit_m(u0, d, c, f[16:14], f[18:17], f[23:19], f[24]), u0};
    return {unit_m(c, d, a, f[16:14], f[18:17], f[23:19], f[24]), u0};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input logic [31:0] d, input logic [24:0] f);
    opa = a; opb = b; opc = c; opd = d; cfg = f;
  endtask

  task automatic run(input string tag, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] c, input logic [31:0] d, input logic [24:0] f);
    drive(a, b, c, d, f);
    @(negedge clk);
    check(tag, {res_hi, res_lo}, model(a, b, c, d, f));
  endtask

  task automatic run_lit(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic [31:0] d, input logic [24:0] f,
                         input logic [63:0] exp);
    drive(a, b, c, d, f);
    @(negedge clk);
    check(tag, {res_hi, res_lo}, exp);
  endtask

  initial begin
    logic [63:0] ref_v;
    logic [24:0] f;
    void'($urandom(32'd20240611));
    drive(32'h1234, 32'h55, 32'h9, 32'h7, mk(0,0,3'd0,2'd0,5'd0,0,0,3'd0,2'd0,5'd0,0));
    repeat (3) @(negedge clk);
    check("R1 reset clears results", {res_hi, res_lo}, 64'h0);
    rst_n = 1'b1;
    #1;
    check("R1 no change before edge", {res_hi, res_lo}, 64'h0);
    @(negedge clk);
    check("R1 registered after edge", {res_hi, res_lo}, {32'h9 + 32'h7, 32'h1234 + 32'h55});

    // R2 every ALU code, independent mode, no shift
    for (int k = 0; k < 8; k++)
      run("R2 alu code", 32'hF0F0_1234, 32'h0FF0_8765, 32'h0000_0010, 32'h0000_0003,
          mk(0,0,3'(k),2'd0,5'd0,0,0,3'(7-k),2'd0,5'd0,0));
    run_lit("R2 rsub", 32'd5, 32'd12, 32'd0, 32'd0, mk(0,0,3'd7,2'd0,5'd0,0,0,3'd2,2'd0,5'd0,0),
            {32'h0, 32'd7});

    // R3 shift kinds
    run_lit("R3 sra", 32'h8000_0000, 32'h0, 32'h0, 32'h0,
            mk(0,0,3'd0,2'd2,5'd31,0,0,3'd0,2'd0,5'd0,0), {32'h0, 32'hFFFF_FFFF});
    run_lit("R3 ror", 32'h1234_5678, 32'h0, 32'h0, 32'h0,
            mk(0,0,3'd3,2'd3,5'd4,0,0,3'd0,2'd0,5'd0,0), {32'h0, 32'h8123_4567});
    run("R3 srl/sll", 32'hDEAD_BEEF, 32'h1, 32'h3, 32'h4, mk(0,0,3'd4,2'd1,5'd7,0,0,3'd1,2'd0,5'd9,0));

    // R4 MAC select, R8 sign bit without effect outside wide mode
    run_lit("R4 mac both units", 32'd7, 32'd6, 32'd100, 32'd3,
            mk(0,0,3'd1,2'd1,5'd3,1,0,3'd0,2'd0,5'd0,1), {32'd307, 32'd142});
    run_lit("R8 sign bit no effect 32b", 32'hFFFF_FFFF, 32'd2, 32'd0, 32'd0,
            mk(0,0,3'd0,2'd0,5'd0,1,1,3'd0,2'd0,5'd0,0), {32'd0, 32'hFFFF_FFFE});

    // R5 operand routing
    run_lit("R5 unit1 uses c,d,a", 32'd1, 32'd2, 32'd10, 32'd4,
            mk(0,0,3'd0,2'd0,5'd0,0,0,3'd1,2'd0,5'd0,1), {32'd41, 32'd3});

    // R6 chained feed
    run_lit("R6 chain feed shifted", 32'd3, 32'd5, 32'd1, 32'd100,
            mk(1,0,3'd0,2'd0,5'd2,0,0,3'd0,2'd0,5'd0,0), {32'd132, 32'd32});
    run_lit("R6 chain feed mac", 32'd3, 32'd5, 32'd1, 32'd10,
            mk(1,0,3'd0,2'd0,5'd0,1,0,3'd0,2'd0,5'd0,1), {32'd161, 32'd16});

    // R7 wide arithmetic, carry and borrow across words
    run_lit("R7 wide add carry", 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h0,
            mk(1,1,3'd0,2'd1,5'd5,0,0,3'd5,2'd2,5'd3,1), 64'h0000_0001_0000_0000);
    run_lit("R7 wide sub borrow", 32'h0, 32'h1, 32'h0, 32'h0,
            mk(1,1,3'd1,2'd0,5'd9,0,0,3'd0,2'd0,5'd0,0), 64'hFFFF_FFFF_FFFF_FFFF);
    run_lit("R7 wide rsub borrow", 32'h5, 32'h2, 32'h0, 32'h3,
            mk(1,1,3'd7,2'd3,5'd1,0,0,3'd4,2'd0,5'd0,0), 64'h0000_0002_FFFF_FFFD);
    run_lit("R7 wide logic wordwise", 32'hFF00_FF00, 32'h0F0F_0F0F, 32'hAAAA_AAAA, 32'hFFFF_0000,
            mk(1,1,3'd2,2'd0,5'd8,0,0,3'd3,2'd1,5'd4,1), 64'hAAAA_0000_0F00_0F00);

    // R8 wide MAC signed and unsigned
    run_lit("R8 wide mac signed", 32'hFFFF_FFFF, 32'd2, 32'd0, 32'd0,
            mk(1,1,3'd0,2'd0,5'd0,1,1,3'd0,2'd0,5'd0,0), 64'hFFFF_FFFF_FFFF_FFFE);
    run_lit("R8 wide mac unsigned", 32'hFFFF_FFFF, 32'd2, 32'd5, 32'd1,
            mk(1,1,3'd0,2'd0,5'd0,1,0,3'd0,2'd0,5'd0,0), 64'h0000_0003_0000_0003);

    // R9 wide bit ignored when not chained
    f = mk(0,1,3'd0,2'd0,5'd0,0,0,3'd1,2'd0,5'd0,0);
    ref_v = {32'd10 - 32'd4, 32'hFFFF_FFFF + 32'd1};
    run_lit("R9 wide ignored", 32'hFFFF_FFFF, 32'd1, 32'd10, 32'd4, f, ref_v);

    for (int i = 0; i < 3000; i++) begin
      f = 25'($urandom);
      run("R2-mix random R3 R4 R5 R6 R7 R8", $urandom, $urandom, $urandom, $urandom, f);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule